// File: doc/BRIEF.md
# Chained Key-Word CRC Checker

This block computes an 8-bit check value over a 128-bit key that is presented as four 32-bit words. It works through the words one at a time and handles one key bit per clock. Before a word is shifted in, the block masks it with a pattern. The pattern depends on the word's position. For every word after the first, it also depends on the 8-bit result of the word before. Each word starts from a cleared CRC register, and a constant is folded into its result. The result of the last word is the check value.

A controller places the key on `key_i` and the reference value on `expected_i`, then pulses `start_i`. It waits for the one-cycle `done_o` pulse and reads `crc_o` and `match_o`. Both outputs hold until the next accepted start. The key and the reference value must stay stable while `busy_o` is high.

Top module: `keychk_crc8`

## Requirements
- R1: While `rst` is high at a clock edge, the block goes to idle, and after that edge `busy_o`, `done_o`, `crc_o` and `match_o` are all 0.
- R2: A `start_i` sampled high while the block is idle starts a computation. From the next cycle `busy_o` is 1 and `crc_o` and `match_o` read 0.
- R3: `done_o` rises exactly 132 cycles after the accepting edge, which is one load cycle plus 32 shift cycles for each of the four words. It is high for one cycle only, and `busy_o` falls in that same cycle.
- R4: Word j is `key_i[32*j+31:32*j]`, and the words are handled in the order 0, 1, 2, 3. Word 0 is XORed with 0xAA55AA55. Word j (j ≥ 1) is XORed with {S, C, S, C}, one byte per field from the most significant byte down. Here C is the previous word's result and S is 0x03, 0x18 or 0xC0 for j = 1, 2 or 3.
- R5: Each word starts from a CRC register of 0 and is shifted in MSB first over 32 steps. In each step the register shifts left. The feedback bit is register bit 7 XOR the key bit, and when it is 1 the register is XORed with 0x07. After the 32nd step the register is XORed with 0x55, and that value is the word's result.
- R6: `crc_o` shows the result of word 3 from the `done_o` cycle and holds it until the next accepted start.
- R7: `match_o` is 1 exactly when the final value equals `expected_i` as sampled at completion. It holds until the next accepted start.
- R8: A `start_i` pulse while `busy_o` is high has no effect: the running computation still completes on schedule, with the same value.
- R9: A reset asserted in the middle of a computation abandons it. The block returns to the idle state of R1 and accepts a new start afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin a computation when idle |
| key_i | input | 128 | Four key words, word j in bits 32j+31..32j |
| expected_i | input | 8 | Reference check value |
| busy_o | output | 1 | Computation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| crc_o | output | 8 | Final check value |
| match_o | output | 1 | Final value equals the reference |

## Verification
The all-zero key leaves only the fixed 0xAA55AA55 seed and the per-word strobes to shape the result. That exposes a wrong seed, a wrong strobe or a wrong bit order on its own. The all-ones key inverts every data bit, so a feedback term taken from the wrong side of the XOR shows up. Random keys exercise how each word's result feeds the next word's mask. A reference value that differs in one bit separates a true comparison from a `match_o` that is tied high. A start pulse injected mid-run, back-to-back runs and a reset mid-run test that the schedule ignores extra starts and recovers cleanly.

// File: rtl/keychk_pkg.sv
package keychk_pkg;
    localparam int WORD_W  = 32;
    localparam int N_WORDS = 4;
    localparam int CRC_W   = 8;
    localparam int KEY_W   = WORD_W * N_WORDS;
    localparam int WIDX_W  = $clog2(N_WORDS);
    localparam int BITC_W  = $clog2(WORD_W);
    localparam int RUN_CYC = N_WORDS * (WORD_W + 1);

    localparam logic [CRC_W-1:0]  POLY    = 8'h07;
    localparam logic [CRC_W-1:0]  XOR_OUT = 8'h55;
    localparam logic [WORD_W-1:0] SEED0   = 32'hAA55AA55;
    // strobe byte per word index; entry 0 unused (word 0 uses SEED0)
    localparam logic [N_WORDS*CRC_W-1:0] STROBES = {8'hC0, 8'h18, 8'h03, 8'h00};

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_SHIFT = 2'd2
    } kstate_e;

    typedef struct packed {
        kstate_e             st;
        logic [WIDX_W-1:0]   widx;
        logic [BITC_W-1:0]   bitc;
        logic [WORD_W-1:0]   shreg;
        logic [CRC_W-1:0]    crc;
        logic [CRC_W-1:0]    prev;
        logic [CRC_W-1:0]    res;
        logic                match;
        logic                done;
    } kregs_t;
endpackage

// File: rtl/keychk_mask.sv
module keychk_mask
    import keychk_pkg::*;
(
    input  logic [WIDX_W-1:0] widx_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic [CRC_W-1:0]  prev_i,
    output logic [WORD_W-1:0] masked_o
);
    logic [CRC_W-1:0] strobe;

    always_comb begin
        strobe = STROBES[widx_i*CRC_W +: CRC_W];
        if (widx_i == '0) begin
            masked_o = word_i ^ SEED0;
        end else begin
            masked_o = word_i ^ {strobe, prev_i, strobe, prev_i};
        end
    end
endmodule

// File: rtl/keychk_step.sv
module keychk_step
    import keychk_pkg::*;
(
    input  logic [CRC_W-1:0] crc_i,
    input  logic             bit_i,
    output logic [CRC_W-1:0] crc_o
);
    logic fb;

    always_comb begin
        fb    = crc_i[CRC_W-1] ^ bit_i;
        crc_o = {crc_i[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
endmodule

// File: rtl/keychk_crc8.sv
module keychk_crc8
    import keychk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [KEY_W-1:0] key_i,
    input  logic [CRC_W-1:0] expected_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [CRC_W-1:0] crc_o,
    output logic             match_o
);
    kregs_t q, d;

    logic [WORD_W-1:0] cur_word;
    logic [WORD_W-1:0] masked;
    logic [CRC_W-1:0]  step_out;
    logic [CRC_W-1:0]  word_res;

    assign cur_word = key_i[q.widx*WORD_W +: WORD_W];

    keychk_mask u_mask (
        .widx_i   (q.widx),
        .word_i   (cur_word),
        .prev_i   (q.prev),
        .masked_o (masked)
    );

    keychk_step u_step (
        .crc_i (q.crc),
        .bit_i (q.shreg[WORD_W-1]),
        .crc_o (step_out)
    );

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        word_res = step_out ^ XOR_OUT;
        case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.st    = ST_LOAD;
                    d.widx  = '0;
                    d.res   = '0;
                    d.match = 1'b0;
                    d.prev  = '0;
                end
            end
            ST_LOAD: begin
                d.shreg = masked;
                d.crc   = '0;
                d.bitc  = '0;
                d.st    = ST_SHIFT;
            end
            ST_SHIFT: begin
                d.crc   = step_out;
                d.shreg = {q.shreg[WORD_W-2:0], 1'b0};
                d.bitc  = q.bitc + 1'b1;
                if (q.bitc == BITC_W'(WORD_W - 1)) begin
                    d.crc  = word_res;
                    d.prev = word_res;
                    if (q.widx == WIDX_W'(N_WORDS - 1)) begin
                        d.st    = ST_IDLE;
                        d.res   = word_res;
                        d.match = (word_res == expected_i);
                        d.done  = 1'b1;
                    end else begin
                        d.widx = q.widx + 1'b1;
                        d.st   = ST_LOAD;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy_o  = (q.st != ST_IDLE);
    assign done_o  = q.done;
    assign crc_o   = q.res;
    assign match_o = q.match;
endmodule

// File: rtl/keychk_crc8_chk.sv
module keychk_crc8_chk
    import keychk_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic             busy_o,
    input logic             done_o,
    input logic [CRC_W-1:0] crc_o,
    input logic             match_o
);
    logic [15:0] busy_cnt;

    always_ff @(posedge clk) begin
        if (rst || !busy_o) begin
            busy_cnt <= '0;
        end else begin
            busy_cnt <= busy_cnt + 1'b1;
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!busy_o && !done_o && crc_o == '0 && !match_o));

    assert_start_clears_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> ($past(start_i) && crc_o == '0 && !match_o));

    assert_done_latency_R3: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (busy_cnt == 16'(RUN_CYC) && !busy_o));

    assert_done_single_R3: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_result_held_R6: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !start_i) |=> ($stable(crc_o) && $stable(match_o)));

    assert_busy_no_restart_R8: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i && !done_o) |=> (busy_o || done_o));
endmodule

bind keychk_crc8 keychk_crc8_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .crc_o   (crc_o),
    .match_o (match_o)
);

// File: tb/sim_keychk_crc8.sv
module sim_keychk_crc8;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start_i = 1'b0;
    logic [127:0] key_i = '0;
    logic [7:0]   expected_i = '0;
    logic         busy_o, done_o, match_o;
    logic [7:0]   crc_o;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    keychk_crc8 u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .key_i(key_i),
        .expected_i(expected_i), .busy_o(busy_o), .done_o(done_o),
        .crc_o(crc_o), .match_o(match_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural model of the chained check value (R4, R5)
    function automatic logic [7:0] model(input logic [127:0] k);
        byte unsigned strobe[4] = '{8'h00, 8'h03, 8'h18, 8'hC0};
        logic [7:0]  c = 8'h00;
        logic [31:0] w;
        for (int j = 0; j < 4; j++) begin
            w = k[32*j +: 32];
            if (j == 0) w = w ^ 32'hAA55AA55;
            else        w = w ^ {strobe[j], c, strobe[j], c};
            c = 8'h00;
            for (int i = 31; i >= 0; i--) begin
                logic fb;
                fb = c[7] ^ w[i];
                c  = {c[6:0], 1'b0};
                if (fb) c = c ^ 8'h07;
            end
            c = c ^ 8'h55;
        end
        return c;
    endfunction

    task automatic run(input logic [127:0] k, input logic [7:0] e, input bit poke, input string lbl);
        logic [7:0] want;
        want = model(k);
        key_i = k;
        expected_i = e;
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        for (int n = 0; n <= 134; n++) begin
            if (n > 0) @(negedge clk);
            if (poke && n == 40) start_i = 1'b1;
            if (poke && n == 41) start_i = 1'b0;
            if (n == 0) begin
                chk({"R2 busy ", lbl}, busy_o, 1);
                chk({"R2 crc cleared ", lbl}, crc_o, 0);
                chk({"R2 match cleared ", lbl}, match_o, 0);
            end
            chk({poke ? "R8 busy " : "R3 busy ", lbl}, busy_o, (n < 132));
            chk({poke ? "R8 done " : "R3 done ", lbl}, done_o, (n == 132));
            if (n >= 132) begin
                chk({"R4/R5/R6 crc ", lbl}, crc_o, want);
                chk({"R7 match ", lbl}, match_o, (want == e));
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 busy", busy_o, 0);
        chk("R1 done", done_o, 0);
        chk("R1 crc", crc_o, 0);
        chk("R1 match", match_o, 0);

        run(128'h0, model(128'h0), 0, "zeros");
        run({128{1'b1}}, model({128{1'b1}}), 0, "ones");
        for (int r = 0; r < 6; r++) begin
            logic [127:0] k;
            k = {$urandom, $urandom, $urandom, $urandom};
            run(k, model(k), 0, "random");
        end
        begin
            logic [127:0] k;
            k = {$urandom, $urandom, $urandom, $urandom};
            run(k, model(k) ^ 8'h01, 0, "wrong expected");
            run(k, model(k), 1, "start while busy");
        end

        // R9: reset in the middle of a run
        key_i = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        repeat (30) @(negedge clk);
        chk("R9 busy before reset", busy_o, 1);
        rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        chk("R9 busy", busy_o, 0);
        chk("R9 done", done_o, 0);
        chk("R9 crc", crc_o, 0);
        chk("R9 match", match_o, 0);
        run(key_i, model(key_i), 0, "after reset");

        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!finished) begin
            finished = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule